// File: doc/BRIEF.md
# NRZ Bit-Clock Recovery Loop

This block recovers a bit clock from a serial NRZ stream that is oversampled at a fixed number of samples per symbol. A phase counter advances once for each accepted sample. On each accepted sample the block compares the new data bit with the bit from the previous accepted sample. A change of level is a transition. Each transition is sorted by the counter value at which it occurs: too early, too late, or inside a tolerance window around the middle of the count.

At the end of each symbol the block picks how long that symbol lasts from what it saw during the symbol. The symbol is shortened or lengthened by a fixed correction step, or it keeps its nominal length. This is a first-order bang-bang loop. Its steady state puts data transitions at mid-count, so the counter wrap falls at the middle of each data bit.

Two outputs feed a downstream sampler. The first is a square recovered clock whose rising edge lines up with the wrap. The second is a one-cycle strobe that marks the wrap.

Top module: `bitsync_dpll`

## Requirements
- R1: A synchronous active-high reset clears the phase counter, the previous-sample bit (to 0) and both direction flags. After reset `rec_clk` is 1 and `bit_strobe` is 0. The first symbol after reset, with data held at 0, lasts N samples even if a transition had been flagged before the reset.
- R2: With no data transition during a symbol, the symbol lasts N accepted samples, so `bit_strobe` pulses every N samples.
- R3: A transition seen at counter value c, where 2c < N-X, marks the symbol early. With no late mark, the symbol lasts N-X samples.
- R4: A transition seen at counter value c, where 2c > N+X, marks the symbol late. With no early mark, the symbol lasts N+X samples. This also holds when the transition is seen at count N-1 itself. The counter never exceeds N-1+X.
- R5: A transition at a counter value c with N-X <= 2c <= N+X marks nothing, and the symbol lasts N samples.
- R6: A symbol marked both early and late lasts N samples.
- R7: `rec_clk` is 1 while the counter is at most N/2 and 0 above it. In each symbol it is therefore high for the first N/2+1 samples. It is 1 whenever `bit_strobe` is 1.
- R8: `bit_strobe` is high for exactly one clock cycle, in the cycle that follows the accepted sample that ends a symbol. The counter reads 0 in that cycle.
- R9: While `sample_en` is 0, the counter, the flags, the previous-sample bit, `rec_clk` and `bit_strobe` (held at 0) keep their values. Data changes during that time are not seen as transitions unless the level differs at the next accepted sample.
- R10: For an alternating data stream at exactly N samples per bit with any phase offset, transitions settle at counter values c with N-X <= 2c <= N+X, and symbols then last N samples.
- R11: For an alternating stream whose bit lasts N+X samples, the strobe spacing settles at N+X samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Accepts the current data bit and advances the loop |
| data_in | input | 1 | Oversampled NRZ serial data |
| rec_clk | output | 1 | Recovered bit clock; rises at the wrap, mid-bit once locked |
| bit_strobe | output | 1 | One-cycle pulse at each symbol wrap |

## Verification
Single symbols are driven from a known phase with a transition placed at a chosen count. Counts are chosen on each side of the tolerance window, on its centre, and at the final count, and paired early and late transitions are also driven. The measured symbol length then tells shorten, keep and lengthen apart. Alternating streams with two opposite phase offsets show that the loop converges from either side and comes to rest inside the window. A stream running slower than nominal shows that the loop follows a rate offset rather than only a phase offset. A gated-enable run with an even number of data toggles shows that only accepted samples count. A reset taken with a pending early mark and a high previous bit shows that the reset clears both.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;

    typedef struct packed {
        logic early;
        logic late;
    } dir_flags_t;

    typedef enum logic [1:0] {
        STEP_SHORT = 2'd0,
        STEP_NOMINAL = 2'd1,
        STEP_LONG = 2'd2
    } step_e;

    // Early alone shortens; late alone lengthens; none or both keep nominal.
    function automatic step_e pick_step(dir_flags_t f);
        if (f.early && !f.late) return STEP_SHORT;
        if (f.late && !f.early) return STEP_LONG;
        return STEP_NOMINAL;
    endfunction

endpackage

// File: rtl/bitsync_edge_detect.sv
module bitsync_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic data_in,
    output logic trans
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else if (en) prev_q <= data_in;
    end

    assign trans = data_in ^ prev_q;
endmodule

// File: rtl/bitsync_phase_classify.sv
module bitsync_phase_classify
    import bitsync_pkg::*;
#(
    parameter int N  = 12,
    parameter int X  = 1,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          trans,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    output dir_flags_t    flags_nxt,
    output dir_flags_t    flags_q
);
    // early when 2c < N-X, late when 2c > N+X
    localparam logic [CW-1:0] EARLY_BELOW = CW'((N - X + 1) / 2);
    localparam logic [CW-1:0] LATE_ABOVE  = CW'((N + X) / 2);

    always_comb begin
        flags_nxt = flags_q;
        if (trans && (cnt < EARLY_BELOW)) flags_nxt.early = 1'b1;
        if (trans && (cnt > LATE_ABOVE))  flags_nxt.late  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            flags_q <= '0;
        else if (en) begin
            if (wrap)       flags_q <= '0;
            else            flags_q <= flags_nxt;
        end
    end
endmodule

// File: rtl/bitsync_phase_counter.sv
module bitsync_phase_counter
    import bitsync_pkg::*;
#(
    parameter int N  = 12,
    parameter int X  = 1,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  step_e         step,
    output logic [CW-1:0] cnt_q,
    output logic          wrap,
    output logic          strobe_q
);
    localparam logic [CW-1:0] LAST_SHORT = CW'(N - 1 - X);
    localparam logic [CW-1:0] LAST_NOM   = CW'(N - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(N - 1 + X);

    logic [CW-1:0] last;

    always_comb begin
        unique case (step)
            STEP_SHORT: last = LAST_SHORT;
            STEP_LONG:  last = LAST_LONG;
            default:    last = LAST_NOM;
        endcase
    end

    assign wrap = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= en && wrap;
            if (en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bitsync_dpll.sv
module bitsync_dpll
    import bitsync_pkg::*;
#(
    parameter int N = 12,
    parameter int X = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic data_in,
    output logic rec_clk,
    output logic bit_strobe
);
    localparam int CW = $clog2(N + X + 1);
    localparam logic [CW-1:0] HALF = CW'(N / 2);

    logic          trans;
    logic          wrap;
    logic [CW-1:0] phase_cnt;
    dir_flags_t    flags_nxt;
    dir_flags_t    flags_q;
    step_e         step;

    bitsync_edge_detect u_edge (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_en),
        .data_in (data_in),
        .trans   (trans)
    );

    bitsync_phase_classify #(.N(N), .X(X), .CW(CW)) u_class (
        .clk       (clk),
        .rst       (rst),
        .en        (sample_en),
        .trans     (trans),
        .wrap      (wrap),
        .cnt       (phase_cnt),
        .flags_nxt (flags_nxt),
        .flags_q   (flags_q)
    );

    assign step = pick_step(flags_nxt);

    bitsync_phase_counter #(.N(N), .X(X), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (sample_en),
        .step     (step),
        .cnt_q    (phase_cnt),
        .wrap     (wrap),
        .strobe_q (bit_strobe)
    );

    assign rec_clk = (phase_cnt <= HALF);
endmodule

// File: rtl/bitsync_dpll_chk.sv
module bitsync_dpll_chk #(
    parameter int N  = 12,
    parameter int X  = 1,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sample_en,
    input logic          rec_clk,
    input logic          bit_strobe,
    input logic [CW-1:0] cnt,
    input logic          early,
    input logic          late
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !bit_strobe && !early && !late && rec_clk));

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe);

    a_r8_strobe_at_zero: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> (cnt == '0));

    a_r7_strobe_clk_high: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |-> rec_clk);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(cnt) && !bit_strobe && $stable(early) && $stable(late)));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(N - 1 + X));

    a_r4_longest_wraps: assert property (@(posedge clk) disable iff (rst)
        (sample_en && cnt == CW'(N - 1 + X)) |=> bit_strobe);
endmodule

bind bitsync_dpll bitsync_dpll_chk #(.N(N), .X(X), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_en  (sample_en),
    .rec_clk    (rec_clk),
    .bit_strobe (bit_strobe),
    .cnt        (phase_cnt),
    .early      (flags_q.early),
    .late       (flags_q.late)
);

// File: tb/bitsync_dpll_tb.sv
`timescale 1ns/1ps
module bitsync_dpll_tb;
    localparam int N = 12;
    localparam int X = 1;
    localparam int WIN_LO = (N - X + 1) / 2;
    localparam int WIN_HI = (N + X) / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b1;
    logic data_in = 1'b0;
    logic rec_clk;
    logic bit_strobe;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bitsync_dpll #(.N(N), .X(X)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .data_in    (data_in),
        .rec_clk    (rec_clk),
        .bit_strobe (bit_strobe)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sample_en = 1'b1;
        data_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Entered at a negedge where the next edge processes count 0.
    // Toggles data at counts p1 and p2 (-1 = none) and measures the symbol.
    task automatic run_sym(int p1, int p2, int exp_len, string req);
        int len = 0;
        int clk_err = 0;
        do begin
            if (len == p1 || len == p2) data_in = ~data_in;
            @(negedge clk);
            len++;
            if (!bit_strobe && rec_clk != (len <= N / 2)) clk_err++;
        end while (!bit_strobe && len < 3 * N);
        check(len == exp_len, req, len, exp_len);
        check(clk_err == 0, "R7 clock shape", clk_err, 0);
        check(bit_strobe && rec_clk, "R8 strobe with clock high", int'(bit_strobe & rec_clk), 1);
    endtask

    task automatic t_reset();
        do_reset();
        check(rec_clk == 1'b1 && bit_strobe == 1'b0, "R1 reset outputs",
              int'({rec_clk, bit_strobe}), 2);
        // early mark pending and previous bit high, then reset with data 0
        repeat (2) @(negedge clk);
        data_in = 1'b1;
        repeat (2) @(negedge clk);
        do_reset();
        run_sym(-1, -1, N, "R1 flags and previous bit cleared");
    endtask

    task automatic t_single_symbols();
        do_reset();
        run_sym(-1, -1, N, "R2 no transition");
        run_sym(-1, -1, N, "R2 no transition repeat");
        run_sym(3, -1, N - X, "R3 early transition");
        run_sym(WIN_LO - 1, -1, N - X, "R3 early at window edge");
        run_sym(9, -1, N + X, "R4 late transition");
        run_sym(WIN_HI + 1, -1, N + X, "R4 late at window edge");
        run_sym(N - 1, -1, N + X, "R4 late at final count");
        run_sym(N / 2, -1, N, "R5 mid-window transition");
        run_sym(WIN_LO, -1, N, "R5 window low edge");
        run_sym(2, 9, N, "R6 early and late");
    endtask

    task automatic t_idle();
        int len = 0;
        int err = 0;
        logic held;
        do_reset();
        repeat (4) begin
            @(negedge clk);
            len++;
        end
        sample_en = 1'b0;
        held = rec_clk;
        for (int i = 0; i < 6; i++) begin
            data_in = ~data_in;
            @(negedge clk);
            if (bit_strobe || rec_clk != held) err++;
        end
        sample_en = 1'b1;
        check(err == 0, "R9 outputs held while idle", err, 0);
        do begin
            @(negedge clk);
            len++;
        end while (!bit_strobe && len < 3 * N);
        check(len == N, "R9 only accepted samples counted", len, N);
    endtask

    // Alternating stream with bit period per_bit, phase offset off.
    task automatic t_stream(int per_bit, int off, string req);
        int pos = 0;
        int ilen = 0;
        int bad_pos = 0;
        int bad_len = 0;
        int seen = 0;
        logic last_d = 1'b0;
        do_reset();
        for (int t = 0; t < 400; t++) begin
            data_in = logic'(((t + off) / per_bit) % 2);
            if (data_in != last_d && t >= 200) begin
                seen++;
                if (per_bit == N && (pos < WIN_LO || pos > WIN_HI)) bad_pos++;
            end
            last_d = data_in;
            @(negedge clk);
            ilen++;
            if (bit_strobe) begin
                if (t >= 200 && ilen != per_bit) bad_len++;
                pos = 0;
                ilen = 0;
            end else begin
                pos++;
            end
        end
        check(seen > 5, {req, " transitions present"}, seen, 6);
        check(bad_pos == 0, {req, " transition inside window"}, bad_pos, 0);
        check(bad_len == 0, {req, " settled spacing"}, bad_len, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single_symbols();
        t_idle();
        t_stream(N, 10, "R10 lead offset");
        t_stream(N, 3, "R10 lag offset");
        t_stream(N + X, 5, "R11 rate offset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule